// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (ten-instruction subset)

This block is a small 32-bit processor core that completes one instruction on every rising clock edge. It fetches the word at the program counter over a combinational instruction port, decodes it, reads up to two general registers, and runs the ALU. In the same cycle it writes back to a register or to data memory and selects the next program counter. Data memory is reached through a word port made of address, write data, write enable and a combinational read data input.

The supported operations are register-register add, subtract, AND, OR and signed set-less-than, add-immediate, word load, word store, branch-if-equal and absolute jump. The register file has 32 entries of 32 bits, with two read ports and one write port. Entry 0 is hard-wired to zero. The core is meant as a compact control engine inside a larger chip, with its memories supplied by the surrounding logic.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, so `imem_addr` reads 0 after that edge.
- R2: Any instruction other than a taken branch or a jump moves `imem_addr` to its current value plus 4 at the next rising edge.
- R3: Opcode 0 with function field [5:0] of 0x20 (add), 0x22 (subtract), 0x24 (AND) or 0x25 (OR) writes the 32-bit wrapping result of rs[25:21] op rt[20:16] into rd[15:11].
- R4: Opcode 0 with function 0x2A writes 1 into rd when rs is less than rt as two's-complement values, and 0 otherwise.
- R5: Opcode 0x08 writes rs plus the sign-extended immediate [15:0] into rt, wrapping at 32 bits.
- R6: Opcode 0x23 drives `dmem_addr` with rs plus the sign-extended offset [15:0] and writes `dmem_rdata` into rt.
- R7: Opcode 0x2B drives `dmem_addr` as in R6, `dmem_wdata` with rt and `dmem_we` high, and leaves the register file unchanged. `dmem_we` is low for every other instruction.
- R8: Register 0 reads as zero whatever was written to it.
- R9: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended offset times 4, which covers backward offsets. If they differ, the next PC is PC+4.
- R10: Opcode 0x02 sets the next PC to bits [31:28] of PC+4, followed by the 26-bit target field, followed by two zero bits.
- R11: Any other opcode, or an opcode-0 word with another function code, writes neither a register nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
Every register value lives inside the core, so a wrong register state is only seen when a later store writes it out or a later branch steers the PC. Each bench program therefore ends in a store, and the stored word appears in data memory at the edge of that store, a few cycles after the faulty write. A wrong PC shows one edge later on `imem_addr`, and a wrong decode shows in the same cycle as a stray or missing `dmem_we`.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RSEL_W = $clog2(NREGS);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    src_imm;
        logic    mem_we;
        logic    mem_to_reg;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]  opcode;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [4:0]  shamt;
        logic [5:0]  funct;
    } instr_t;

    function automatic ctrl_t decode_word(input logic [5:0] op, input logic [5:0] fn);
        ctrl_t c;
        c = '{default: '0, alu_op: ALU_ADD};
        unique case (op)
            OP_RTYPE: begin
                c.dst_is_rd = 1'b1;
                c.reg_we    = 1'b1;
                case (fn)
                    FN_ADD:  c.alu_op = ALU_ADD;
                    FN_SUB:  c.alu_op = ALU_SUB;
                    FN_AND:  c.alu_op = ALU_AND;
                    FN_OR:   c.alu_op = ALU_OR;
                    FN_SLT:  c.alu_op = ALU_SLT;
                    default: c.reg_we = 1'b0;
                endcase
            end
            OP_ADDI:  begin c.reg_we = 1'b1; c.src_imm = 1'b1; end
            OP_LOAD:  begin c.reg_we = 1'b1; c.src_imm = 1'b1; c.mem_to_reg = 1'b1; end
            OP_STORE: begin c.mem_we = 1'b1; c.src_imm = 1'b1; end
            OP_BEQ:   begin c.branch = 1'b1; c.alu_op = ALU_SUB; end
            OP_JUMP:  c.jump = 1'b1;
            default:  ;
        endcase
        return c;
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int N  = 32,
    parameter int W  = 32,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] rsel_a,
    input  logic [SW-1:0] rsel_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];
    logic [N-1:0] load;

    always_comb begin
        load = '0;
        if (we) load[wsel] = 1'b1;
        load[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (i == 0)
                regs[i] <= '0;
            else if (load[i])
                regs[i] <= wdata;
        end
    end

    assign rdata_a = (rsel_a == '0) ? '0 : regs[rsel_a];
    assign rdata_b = (rsel_b == '0) ? '0 : regs[rsel_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output instr_t          fields,
    output logic [15:0]     imm,
    output logic [25:0]     target,
    output ctrl_t           ctrl
);
    assign fields = instr_t'(instr);
    assign imm    = instr[15:0];
    assign target = instr[25:0];
    assign ctrl   = decode_word(fields.opcode, fields.funct);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target, jmp_target;
    instr_t          f;
    logic [15:0]     imm;
    logic [25:0]     target;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
    logic            alu_zero, rf_we;
    logic [RSEL_W-1:0] rf_wsel;

    sc_decode dec_i (
        .instr(imem_data), .fields(f), .imm(imm), .target(target), .ctrl(ctrl)
    );

    assign rf_we   = ctrl.reg_we & ~rst;
    assign rf_wsel = ctrl.dst_is_rd ? f.rd : f.rt;

    sc_regfile #(.N(NREGS), .W(XLEN)) rf_i (
        .clk(clk), .we(rf_we), .wsel(rf_wsel), .wdata(wb_data),
        .rsel_a(f.rs), .rsel_b(f.rt), .rdata_a(rs_val), .rdata_b(rt_val)
    );

    assign imm_ext = sext16(imm);
    assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) alu_i (
        .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
    );

    assign wb_data    = ctrl.mem_to_reg ? dmem_rdata : alu_y;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we & ~rst;

    assign pc_plus4   = pc + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:28], target, 2'b00};

    always_comb begin
        if (ctrl.jump)
            pc_next = jmp_target;
        else if (ctrl.branch && alu_zero)
            pc_next = br_target;
        else
            pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign imem_addr = pc;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_data,
    input logic [XLEN-1:0] dmem_addr,
    input logic            dmem_we,
    input logic [XLEN-1:0] rs_val,
    input logic            rf_we
);
    logic [5:0]      op;
    logic [XLEN-1:0] seq_pc, jump_pc, ea;
    logic            rst_q;

    assign op      = imem_data[31:26];
    assign seq_pc  = imem_addr + 32'd4;
    assign jump_pc = {seq_pc[31:28], imem_data[25:0], 2'b00};
    assign ea      = rs_val + {{16{imem_data[15]}}, imem_data[15:0]};

    always_ff @(posedge clk) rst_q <= rst;

    always_comb begin
        if (rst_q == 1'b1)
            p_reset_pc_r1: assert (imem_addr == '0);
    end

    p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (op != OP_BEQ && op != OP_JUMP) |=> imem_addr == $past(seq_pc));

    p_load_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |-> dmem_addr == ea);

    p_store_only_r7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (op == OP_STORE));

    p_store_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STORE) |-> (dmem_we && !rf_we));

    p_zero_read_r8: assert property (@(posedge clk) disable iff (rst)
        (imem_data[25:21] == 5'd0) |-> rs_val == '0);

    p_jump_pc_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JUMP) |=> imem_addr == $past(jump_pc));
endmodule

bind sc_core sc_core_chk chk_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .rs_val(rs_val), .rf_we(rf_we)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] rt_w(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] it_w(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] j_w(input int word);
        return {6'h02, 26'(word)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = j_w(i);
            dmem[i] = 32'hDEAD_0000 + 32'(i);
        end
    endtask

    task automatic start();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] ref_alu(input int k, input logic [31:0] a, input logic [31:0] b);
        case (k)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'h1234_5678, 32'h5, 32'hA5A5_A5A5};
    logic [5:0]  fns  [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    int          imms [6] = '{0, 1, -1, 32'h7FFF, -32768, 32'h1234};

    initial begin
        clear_mem();
        @(negedge clk);
        // R1: reset state of the PC
        imem[0] = j_w(9);
        start();
        chk("R1 pc after reset", imem_addr, 32'd0);
        // R10: jump sets PC from target field
        run(1);
        chk("R10 jump target", imem_addr, 32'd36);
        // R2: sequential advance
        rst = 1'b1; imem[0] = it_w(6'h08, 1, 0, 3);
        start(); run(1);
        chk("R2 pc plus 4", imem_addr, 32'd4);
        chk("R1 no store during program start", dmem[40], 32'hDEAD_0028);

        // R3, R4: register-register sweep
        for (int k = 0; k < 5; k++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    rst = 1'b1; clear_mem();
                    dmem[0] = vals[a]; dmem[1] = vals[b];
                    imem[0] = it_w(6'h23, 1, 0, 0);
                    imem[1] = it_w(6'h23, 2, 0, 4);
                    imem[2] = rt_w(fns[k], 3, 1, 2);
                    imem[3] = it_w(6'h2B, 3, 0, 8);
                    start(); run(6);
                    chk(k == 4 ? "R4 signed slt" : "R3 rtype op", dmem[2], ref_alu(k, vals[a], vals[b]));
                end

        // R5: add-immediate sweep
        for (int a = 0; a < 8; a++)
            for (int m = 0; m < 6; m++) begin
                rst = 1'b1; clear_mem();
                dmem[0] = vals[a];
                imem[0] = it_w(6'h23, 1, 0, 0);
                imem[1] = it_w(6'h08, 3, 1, imms[m]);
                imem[2] = it_w(6'h2B, 3, 0, 8);
                start(); run(5);
                chk("R5 addi", dmem[2], vals[a] + 32'(imms[m]));
            end

        // R6, R7: negative offsets for load and store
        rst = 1'b1; clear_mem();
        dmem[5] = 32'hCAFE_F00D;
        imem[0] = it_w(6'h08, 1, 0, 40);
        imem[1] = it_w(6'h23, 4, 1, -20);
        imem[2] = it_w(6'h2B, 4, 1, -4);
        imem[3] = it_w(6'h2B, 4, 0, 12);
        start(); run(6);
        chk("R6 load negative offset", dmem[9], 32'hCAFE_F00D);
        chk("R7 store base zero", dmem[3], 32'hCAFE_F00D);
        chk("R7 no stray store", dmem[10], 32'hDEAD_000A);

        // R7: store leaves the register file alone (rt stays as loaded)
        rst = 1'b1; clear_mem();
        dmem[0] = 32'h0BAD_BEEF;
        imem[0] = it_w(6'h23, 6, 0, 0);
        imem[1] = it_w(6'h2B, 6, 0, 16);
        imem[2] = it_w(6'h2B, 6, 0, 20);
        start(); run(5);
        chk("R7 store keeps rt", dmem[5], 32'h0BAD_BEEF);

        // R8: register 0 ignores writes
        rst = 1'b1; clear_mem();
        dmem[0] = 32'h1111_2222;
        imem[0] = it_w(6'h23, 1, 0, 0);
        imem[1] = it_w(6'h08, 0, 0, 5);
        imem[2] = rt_w(6'h20, 0, 1, 1);
        imem[3] = it_w(6'h23, 0, 0, 0);
        imem[4] = it_w(6'h2B, 0, 0, 8);
        start(); run(7);
        chk("R8 zero register", dmem[2], 32'd0);

        // R9: forward branch taken / not taken
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b += 3) begin
                rst = 1'b1; clear_mem();
                dmem[0] = vals[a]; dmem[1] = vals[b];
                imem[0] = it_w(6'h23, 1, 0, 0);
                imem[1] = it_w(6'h23, 2, 0, 4);
                imem[2] = it_w(6'h08, 5, 0, 0);
                imem[3] = it_w(6'h04, 2, 1, 1);
                imem[4] = it_w(6'h08, 5, 5, 1);
                imem[5] = it_w(6'h08, 5, 5, 2);
                imem[6] = it_w(6'h2B, 5, 0, 8);
                start(); run(9);
                chk("R9 beq forward", dmem[2], (vals[a] == vals[b]) ? 32'd2 : 32'd3);
            end

        // R9: backward branch loop
        rst = 1'b1; clear_mem();
        imem[0] = it_w(6'h08, 1, 0, 3);
        imem[1] = it_w(6'h08, 2, 0, 0);
        imem[2] = it_w(6'h08, 2, 2, 5);
        imem[3] = it_w(6'h08, 1, 1, -1);
        imem[4] = it_w(6'h04, 0, 1, 1);
        imem[5] = it_w(6'h04, 0, 0, -4);
        imem[6] = it_w(6'h2B, 2, 0, 8);
        start(); run(20);
        chk("R9 beq backward loop", dmem[2], 32'd15);
        chk("R9 pc parked after loop", imem_addr, 32'd28);

        // R11: unsupported opcode and function codes change nothing
        rst = 1'b1; clear_mem();
        dmem[0] = 32'h5A5A_0001;
        imem[0] = it_w(6'h23, 1, 0, 0);
        imem[1] = it_w(6'h3F, 1, 0, 16'h0024);
        imem[2] = rt_w(6'h3F, 1, 0, 0);
        imem[3] = it_w(6'h0D, 1, 0, 4);
        start(); run(3);
        chk("R11 pc advances past unsupported", imem_addr, 32'd12);
        imem[4] = it_w(6'h2B, 1, 0, 8);
        run(3);
        chk("R11 register unchanged", dmem[2], 32'h5A5A_0001);
        chk("R11 no memory write", dmem[9], 32'hDEAD_0009);
        chk("R11 no memory write low", dmem[1], 32'hDEAD_0001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule